// File: doc/BRIEF.md
# SPI Channel Register Front End

This block is the software-visible face of one SPI master channel. A word-addressed register bus reaches six registers: module control, channel configuration, channel status, channel control, transmit data and receive data. The block holds three status flags (receive full, transmit empty, end of transfer). It drives two DMA request lines, one for transmit and one for receive. Each line is gated by its own enable bit in the configuration word.

The serial shift engine sits outside. It sees a pending transmit word through `tx_valid`/`tx_word` and pulses `eng_tx_take` when it takes the word. It pulses `eng_done` when the last bit has left the wire, and it pulses `eng_rx_load` with `eng_rx_data` when a received word is complete. The channel index parameter moves the per-channel registers by five words for each channel, so several copies can share one bus.

Top module: `spi_chan_regs`

## Requirements
- R1: After reset the module control register reads 0x00000004, so the block is in slave mode. All other registers and all status flags read zero. `dma_tx_req`, `dma_rx_req`, `tx_valid` and `chan_en` are low.
- R2: Word addresses (CH = channel index):
  - module control: 0x0A
  - configuration: 0x0B+5*CH
  - status: 0x0C+5*CH
  - control: 0x0D+5*CH
  - transmit: 0x0E+5*CH
  - receive: 0x0F+5*CH

  A read of any other address returns 0. A write to any other address changes no register.
- R3: The module control, configuration, control and transmit registers read back all 32 bits last written. `bus_rdata` takes the read value on the clock edge that samples `bus_rd` and holds it until the next read.
- R4: The status word has RXS in bit 0, TXS in bit 1 and EOT in bit 2, with all other bits zero. Writes to the status register and to the receive register are ignored.
- R5: A write to control with bit 0 = 1 while the channel is disabled sets TXS. A write to transmit while the channel is enabled clears TXS and EOT. `tx_valid` is high exactly when the channel is enabled and TXS is 0.
- R6: While enabled, `eng_tx_take` with TXS = 0 sets TXS, and `eng_done` sets EOT. In the same cycle a transmit write takes precedence over both.
- R7: While enabled, `eng_rx_load` stores `eng_rx_data` in the receive register and sets RXS. A read of the receive register returns the stored word and clears RXS. A load in the same cycle as that read leaves RXS set with the new word.
- R8: `dma_tx_req` is high when configuration bit 14 and TXS are both 1. `dma_rx_req` is high when configuration bit 15 and RXS are both 1.
- R9: A control write with bit 0 = 0 while enabled clears RXS, TXS and EOT and zeroes the receive register. Engine strobes while the channel is disabled have no effect.
- R10: Mode outputs follow module control: `mode_single` = bit 0, `mode_master` = NOT bit 2, `mode_selftest` = bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, registered |
| eng_tx_take | input | 1 | Engine has taken the transmit word |
| eng_done | input | 1 | Last word fully shifted out |
| eng_rx_load | input | 1 | Received word ready |
| eng_rx_data | input | DW | Received word |
| tx_word | output | DW | Transmit register contents |
| tx_valid | output | 1 | Transmit word pending for the engine |
| chan_en | output | 1 | Channel enable |
| cfg_word | output | DW | Configuration register contents |
| mode_single | output | 1 | Single-channel mode |
| mode_master | output | 1 | Master mode |
| mode_selftest | output | 1 | Self-test mode |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The hardest state to reach is the collision cases:
- a receive load in the same cycle as a receive-register read;
- a transmit write in the same cycle as an engine take;
- disabling the channel while a received word is still unread.

The stimulus drives the bus and engine strobes together from one cycle task to reach these collisions. After the disable, it reads the receive and status registers back to show that the stale word is gone. Engine strobes are then sent while the channel is disabled, and status is reread to show they were ignored.

// File: rtl/spi_chan_regs.sv
module spi_chan_regs #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int CH_IDX = 0,
  parameter int TXDMA_BIT = 14,
  parameter int RXDMA_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          eng_tx_take,
  input  logic          eng_done,
  input  logic          eng_rx_load,
  input  logic [DW-1:0] eng_rx_data,
  output logic [DW-1:0] tx_word,
  output logic          tx_valid,
  output logic          chan_en,
  output logic [DW-1:0] cfg_word,
  output logic          mode_single,
  output logic          mode_master,
  output logic          mode_selftest,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam int BANK = 11 + 5 * CH_IDX;
  localparam logic [AW-1:0] A_MOD  = AW'(10);
  localparam logic [AW-1:0] A_CFG  = AW'(BANK);
  localparam logic [AW-1:0] A_STAT = AW'(BANK + 1);
  localparam logic [AW-1:0] A_CTRL = AW'(BANK + 2);
  localparam logic [AW-1:0] A_TX   = AW'(BANK + 3);
  localparam logic [AW-1:0] A_RX   = AW'(BANK + 4);
  localparam logic [DW-1:0] MOD_RST = DW'(4);

  logic [DW-1:0] mod_q, cfg_q, ctrl_q, tx_q, rx_q, rdata_q;
  logic rxs_q, txs_q, eot_q;

  wire wr_mod  = bus_wr && bus_addr == A_MOD;
  wire wr_cfg  = bus_wr && bus_addr == A_CFG;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_tx   = bus_wr && bus_addr == A_TX;
  wire rd_rx   = bus_rd && bus_addr == A_RX;
  wire en      = ctrl_q[0];
  wire turn_on  = wr_ctrl && !en && bus_wdata[0];
  wire turn_off = wr_ctrl && en && !bus_wdata[0];

  logic [DW-1:0] stat_w, rd_mux;
  assign stat_w = {{(DW-3){1'b0}}, eot_q, txs_q, rxs_q};

  always_comb begin
    case (bus_addr)
      A_MOD:   rd_mux = mod_q;
      A_CFG:   rd_mux = cfg_q;
      A_STAT:  rd_mux = stat_w;
      A_CTRL:  rd_mux = ctrl_q;
      A_TX:    rd_mux = tx_q;
      A_RX:    rd_mux = rx_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q <= MOD_RST;
      cfg_q <= '0;
      ctrl_q <= '0;
      tx_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_mod)  mod_q  <= bus_wdata;
      if (wr_cfg)  cfg_q  <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (wr_tx)   tx_q   <= bus_wdata;
      if (bus_rd)  rdata_q <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxs_q <= 1'b0;
      txs_q <= 1'b0;
      eot_q <= 1'b0;
      rx_q  <= '0;
    end else if (turn_off) begin
      rxs_q <= 1'b0;
      txs_q <= 1'b0;
      eot_q <= 1'b0;
      rx_q  <= '0;
    end else if (turn_on) begin
      txs_q <= 1'b1;
    end else if (en) begin
      if (wr_tx) begin
        txs_q <= 1'b0;
        eot_q <= 1'b0;
      end else begin
        if (eng_tx_take && !txs_q) txs_q <= 1'b1;
        if (eng_done) eot_q <= 1'b1;
      end
      if (eng_rx_load) begin
        rx_q  <= eng_rx_data;
        rxs_q <= 1'b1;
      end else if (rd_rx) begin
        rxs_q <= 1'b0;
      end
    end
  end

  assign bus_rdata     = rdata_q;
  assign tx_word       = tx_q;
  assign tx_valid      = en && !txs_q;
  assign chan_en       = en;
  assign cfg_word      = cfg_q;
  assign mode_single   = mod_q[0];
  assign mode_master   = !mod_q[2];
  assign mode_selftest = mod_q[3];
  assign dma_tx_req    = cfg_q[TXDMA_BIT] && txs_q;
  assign dma_rx_req    = cfg_q[RXDMA_BIT] && rxs_q;

  p_dma_rx_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> chan_en);
  p_off_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> (!dma_rx_req && !dma_tx_req && !tx_valid && rx_q == '0));
  p_txwrite_pends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && en && !wr_ctrl) |=> (tx_valid && !eot_q));
  p_take_sets_txs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_take && tx_valid && !bus_wr) |=> !tx_valid);
  p_load_sets_rxs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_load && en && !bus_wr) |=> (rxs_q && rx_q == $past(eng_rx_data)));
  p_read_clears_rxs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && en && !eng_rx_load && !bus_wr) |=> !rxs_q);
endmodule

// File: tb/sim_spi_chan_regs.sv
module sim_spi_chan_regs;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic eng_tx_take = 0, eng_done = 0, eng_rx_load = 0;
  logic [DW-1:0] eng_rx_data = '0;
  logic [DW-1:0] bus_rdata, tx_word, cfg_word;
  logic tx_valid, chan_en, mode_single, mode_master, mode_selftest, dma_tx_req, dma_rx_req;

  spi_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_tx_take(eng_tx_take),
    .eng_done(eng_done), .eng_rx_load(eng_rx_load), .eng_rx_data(eng_rx_data),
    .tx_word(tx_word), .tx_valid(tx_valid), .chan_en(chan_en), .cfg_word(cfg_word),
    .mode_single(mode_single), .mode_master(mode_master), .mode_selftest(mode_selftest),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req));

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [31:0] m_mod, m_cfg, m_ctrl, m_tx, m_rx, m_rd;
  bit m_rxs, m_txs, m_eot;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mod = 32'h4; m_cfg = 0; m_ctrl = 0; m_tx = 0; m_rx = 0; m_rd = 0;
      m_rxs = 0; m_txs = 0; m_eot = 0;
    end else begin
      bit was_on;
      int a;
      was_on = m_ctrl[0];
      a = bus_addr;
      if (bus_rd) begin
        case (a)
          10: m_rd = m_mod;
          11: m_rd = m_cfg;
          12: m_rd = {29'd0, m_eot, m_txs, m_rxs};
          13: m_rd = m_ctrl;
          14: m_rd = m_tx;
          15: m_rd = m_rx;
          default: m_rd = 0;
        endcase
      end
      if (was_on) begin
        if (eng_done) m_eot = 1;
        if (eng_tx_take && !m_txs) m_txs = 1;
        if (bus_wr && a == 14) begin m_txs = 0; m_eot = 0; end
        if (bus_rd && a == 15) m_rxs = 0;
        if (eng_rx_load) begin m_rx = eng_rx_data; m_rxs = 1; end
      end
      if (bus_wr) begin
        case (a)
          10: m_mod = bus_wdata;
          11: m_cfg = bus_wdata;
          13: m_ctrl = bus_wdata;
          14: m_tx = bus_wdata;
          default: ;
        endcase
      end
      if (!was_on && m_ctrl[0]) m_txs = 1;
      if (was_on && !m_ctrl[0]) begin m_rxs = 0; m_txs = 0; m_eot = 0; m_rx = 0; end
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("rdata", bus_rdata, m_rd);
      cmp("tx_valid", {31'd0, tx_valid}, {31'd0, m_ctrl[0] & !m_txs});
      cmp("tx_word", tx_word, m_tx);
      cmp("cfg_word", cfg_word, m_cfg);
      cmp("chan_en", {31'd0, chan_en}, {31'd0, m_ctrl[0]});
      cmp("modes", {29'd0, mode_selftest, mode_master, mode_single},
          {29'd0, m_mod[3], !m_mod[2], m_mod[0]});
      cmp("dma", {30'd0, dma_rx_req, dma_tx_req},
          {30'd0, m_cfg[15] & m_rxs, m_cfg[14] & m_txs});
    end
  end

  task automatic cyc(bit w, bit r, int a, logic [31:0] d,
                     bit tk = 0, bit dn = 0, bit ld = 0, logic [31:0] ldd = 0);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = AW'(a); bus_wdata = d;
    eng_tx_take = tk; eng_done = dn; eng_rx_load = ld; eng_rx_data = ldd;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_tx_take = 0; eng_done = 0; eng_rx_load = 0;
  endtask

  task automatic wr(int a, logic [31:0] d); cyc(1, 0, a, d); endtask
  task automatic rd(int a); cyc(0, 1, a, 0); endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    for (int a = 10; a <= 15; a++) rd(a);
    cur_req = "R10";
    wr(10, 32'h1); rd(10);
    wr(10, 32'hC); rd(10);
    cur_req = "R3";
    wr(11, 32'h1234_0678); rd(11);
    wr(14, 32'hCAFE_F00D); rd(14);
    wr(13, 32'hA500_0000); rd(13);
    cur_req = "R2";
    rd(5); rd(16); rd(63);
    wr(16, 32'hFFFF_FFFF); wr(9, 32'h5555_5555);
    rd(11); rd(13); rd(14); rd(10);
    cur_req = "R4";
    wr(12, 32'hFFFF_FFFF); wr(15, 32'h1111_2222); rd(12); rd(15);
    cur_req = "R5";
    wr(11, 32'h0); wr(13, 32'h1); rd(12);
    wr(14, 32'h0000_00A5); rd(12);
    cur_req = "R6";
    cyc(0, 0, 0, 0, 1); rd(12);
    cyc(0, 0, 0, 0, 0, 1); rd(12);
    cyc(1, 0, 14, 32'h3C, 1, 1); rd(12);
    cyc(0, 0, 0, 0, 1, 1); rd(12);
    cur_req = "R7";
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h0BAD_BEEF); rd(12); rd(15); rd(12);
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h1357_9BDF);
    cyc(0, 1, 15, 0, 0, 0, 1, 32'h2468_ACE0); rd(12); rd(15); rd(12);
    cur_req = "R8";
    wr(11, 32'h0000_C000);
    cyc(0, 0, 0, 0, 0, 0, 1, 32'h77);
    wr(14, 32'h1); cyc(0, 0, 0, 0, 1);
    rd(15); wr(11, 32'h0000_4000); cyc(0, 0, 0, 0, 0, 0, 1, 32'h88);
    wr(11, 32'h0000_8000); rd(15);
    cur_req = "R9";
    cyc(0, 0, 0, 0, 0, 0, 1, 32'hFACE_0001);
    wr(14, 32'h9);
    wr(13, 32'h0); rd(12); rd(15);
    cyc(0, 0, 0, 0, 1, 1, 1, 32'hDEAD_0002); rd(12); rd(15);
    wr(13, 32'h1); rd(12); rd(15);
    wr(13, 32'h0); rd(12);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule